// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Bridge

This block lets a host fetch words from a serial flash device as if it were ordinary memory. Host reads that fall inside a 64 MiB address window become flash read frames. Reads outside the window, misaligned reads and reads made while the controller is in manual sequencing mode get an error response. Each frame is handed to an existing serial shifter, together with the command, option, phase-enable, dummy-cycle, DDR-enable and chip-select timing settings used for mapped reads. These settings use the same encodings as manual sequencing.

The flash address is the offset within the window. Above bit 24 it takes a 4-bit extended-address value, under the control of a 3-bit usage selector. A miss fetches a burst of words, aligned to the burst length, into a small line cache, and holds the host with a wait signal until the line is filled. Later reads inside that line are served from the cache with no new frame. A flush input invalidates the line, so software must pulse it after changing the flash contents or the address settings.

Top module: `xip_read_bridge`

## Requirements
- R1: A read is mapped only when hst_addr[31:26] equals the window base bits and hst_addr[1:0] is 00. Any other read is acknowledged one cycle after it is presented, with hst_err=1, hst_rdata=0 and no frame.
- R2: While mode_manual=1 (manual sequencing), every read is answered with hst_err=1 and no frame. With mode_manual=0, mapped reads proceed.
- R3: The flash byte address of a window offset `off` is {8'h00, off[23:0]} when cfg_ext_sel is 0. For any other cfg_ext_sel value it is {3'b000, cfg_ext_addr, off[24:0]}.
- R4: With cfg_burst_en=1, a frame fetches cfg_burst_m1+1 words (1, 2, 4, 8, 16 or 32), starting at the word offset rounded down to a multiple of that count. With cfg_burst_en=0, it fetches exactly 1 word and cfg_burst_m1 is ignored. fr_addr is the flash address (R3) of the first word and fr_words is the count.
- R5: A read of a word held by the valid line is acknowledged one cycle after it is presented, with the cached word and no frame.
- R6: On a miss, hst_wait stays high from the request until the acknowledge cycle. The returned word is the one the shifter delivered for that word's flash address. hst_wait is low in the acknowledge cycle.
- R7: A frame carries the current cfg_cmd, cfg_opt, cfg_dummy, cfg_ddr and cfg_cs_dly unchanged. fr_phase is {cfg_phase, 4'b1111}: the data byte-mask nibble in bits [3:0] is always all ones.
- R8: A one-cycle pulse on cfg_flush invalidates the line. The next read of a previously cached word issues a new frame.
- R9: Each miss issues exactly one fr_start pulse, one cycle long. Hits and error responses issue none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_manual | input | 1 | 1 = manual sequencing (window reads rejected), 0 = mapped reads |
| hst_req | input | 1 | Host read request, held until hst_ack |
| hst_addr | input | 32 | Host byte address |
| hst_wait | output | 1 | Host held: request pending, not yet acknowledged |
| hst_ack | output | 1 | One-cycle response strobe |
| hst_err | output | 1 | Error response, valid with hst_ack |
| hst_rdata | output | 32 | Read word, valid with hst_ack |
| cfg_burst_en | input | 1 | Burst prefetch enable |
| cfg_burst_m1 | input | 5 | Burst length minus one, in words |
| cfg_flush | input | 1 | Line invalidate pulse |
| cfg_ext_addr | input | 4 | Flash address bits 28:25 |
| cfg_ext_sel | input | 3 | Extended address usage, 0 = 24-bit addressing |
| cfg_cmd | input | 16 | Command and option-command bytes |
| cfg_opt | input | 32 | Option data |
| cfg_phase | input | 28 | Phase enables above the data byte mask |
| cfg_dummy | input | 5 | Dummy cycle setting |
| cfg_ddr | input | 16 | DDR enables per phase |
| cfg_cs_dly | input | 9 | Chip-select timing: three 3-bit delays |
| fr_start | output | 1 | Frame start pulse to the shifter |
| fr_addr | output | 32 | Flash byte address of the first word |
| fr_words | output | 6 | Words to fetch |
| fr_cmd | output | 16 | Frame command bytes |
| fr_opt | output | 32 | Frame option data |
| fr_phase | output | 32 | Frame phase enables, data mask forced |
| fr_dummy | output | 5 | Frame dummy setting |
| fr_ddr | output | 16 | Frame DDR enables |
| fr_cs_dly | output | 9 | Frame chip-select timing |
| rx_valid | input | 1 | Shifter word strobe |
| rx_data | input | 32 | Shifter word, in frame order |

## Verification
Burst lengths from 1 to 32 are swept. Each sweep step makes one miss in the middle of the line and then reads every word of the line, which separates correct alignment, correct word indexing and the hit/miss decision. Reads at the edges of the window, misaligned addresses and manual mode separate the error path from the mapped path. Alternating the extended-address selector on an offset whose bit 24 is set exposes any mix-up in address forming. Flushes between repeated reads, and a disabled burst with a nonzero length field, show whether the cache state and the length field are honoured or ignored.

// File: rtl/xip_pkg.sv
`timescale 1ns/1ps
// Shared field widths, state type and flash address forming for the
// mapped-read bridge. Assumes 32-bit words, 4 bytes each.
package xip_pkg;
    localparam int DATA_W  = 32;
    localparam int CMD_W   = 16;
    localparam int OPT_W   = 32;
    localparam int PHASE_W = 32;
    localparam int MASK_W  = 4;
    localparam int DUMMY_W = 5;
    localparam int DDR_W   = 16;
    localparam int CSD_W   = 9;
    localparam int EXT_W   = 4;
    localparam int SEL_W   = 3;

    typedef enum logic {ST_IDLE, ST_FILL} xip_state_e;

    // Flash byte address from the low 25 offset bits and the extension.
    function automatic logic [31:0] xip_flash_addr(input logic [24:0] off,
                                                   input logic [EXT_W-1:0] ext,
                                                   input logic [SEL_W-1:0] sel);
        if (sel == '0)
            return {8'h00, off[23:0]};
        else
            return {3'b000, ext, off};
    endfunction
endpackage

// File: rtl/xip_addr_map.sv
`timescale 1ns/1ps
// Window decode and line alignment. Purely combinational. Assumes
// WIN_BASE is aligned to the window size and that the burst length
// is a power of two, so it can serve as an alignment mask.
module xip_addr_map
    import xip_pkg::*;
#(
    parameter logic [31:0] WIN_BASE  = 32'h0800_0000,
    parameter int          WIN_BITS  = 26,
    parameter int          MAX_BURST = 32,
    localparam int         WOFF_W    = WIN_BITS - 2,
    localparam int         IDX_W     = $clog2(MAX_BURST)
) (
    input  logic [31:0]       addr,
    input  logic              burst_en,
    input  logic [IDX_W-1:0]  burst_m1,
    input  logic [EXT_W-1:0]  ext_addr,
    input  logic [SEL_W-1:0]  ext_sel,
    output logic              mapped,
    output logic [WOFF_W-1:0] woff,
    output logic [WOFF_W-1:0] base_woff,
    output logic [IDX_W-1:0]  line_mask,
    output logic [31:0]       base_faddr
);
    logic [WIN_BITS-1:0] base_byte;

    // Decode window hit and alignment, then round down to the line start.
    always_comb begin
        mapped     = (addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]) && (addr[1:0] == 2'b00);
        woff       = addr[WIN_BITS-1:2];
        line_mask  = burst_en ? burst_m1 : '0;
        base_woff  = woff & ~{{(WOFF_W-IDX_W){1'b0}}, line_mask};
        base_byte  = {base_woff, 2'b00};
        base_faddr = xip_flash_addr(base_byte[24:0], ext_addr, ext_sel);
    end
endmodule

// File: rtl/xip_line_cache.sv
`timescale 1ns/1ps
// Single-line read cache: holds one burst, its aligned base and its
// length mask. Fills in order from the shifter's word stream. A flush
// during a fill keeps the line invalid after the fill ends.
module xip_line_cache
    import xip_pkg::*;
#(
    parameter int  MAX_BURST = 32,
    parameter int  WOFF_W    = 24,
    localparam int IDX_W     = $clog2(MAX_BURST)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill_start,
    input  logic [WOFF_W-1:0] fill_base,
    input  logic [IDX_W-1:0]  fill_mask,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [WOFF_W-1:0] look_woff,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    output logic              fill_last
);
    logic [DATA_W-1:0] mem [MAX_BURST];
    logic [WOFF_W-1:0] tag_base;
    logic [IDX_W-1:0]  tag_mask;
    logic [IDX_W-1:0]  cnt;
    logic              valid, filling, kill;

    // Store each arriving word at the running fill index.
    always_ff @(posedge clk) begin
        if (filling && rx_valid)
            mem[cnt] <= rx_data;
    end

    // Track line tag, fill progress and validity; flush wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_base <= '0;
            tag_mask <= '0;
            cnt      <= '0;
            valid    <= 1'b0;
            filling  <= 1'b0;
            kill     <= 1'b0;
        end else begin
            if (fill_start) begin
                tag_base <= fill_base;
                tag_mask <= fill_mask;
                cnt      <= '0;
                valid    <= 1'b0;
                filling  <= 1'b1;
                kill     <= 1'b0;
            end else if (filling && rx_valid) begin
                cnt <= cnt + 1'b1;
                if (cnt == tag_mask) begin
                    filling <= 1'b0;
                    valid   <= !kill;
                end
            end
            if (flush) begin
                valid <= 1'b0;
                kill  <= filling && !fill_last;
            end
        end
    end

    // Compare the aligned lookup offset against the stored line.
    always_comb begin
        fill_last = filling && rx_valid && (cnt == tag_mask);
        hit       = valid && ((look_woff & ~{{(WOFF_W-IDX_W){1'b0}}, tag_mask}) == tag_base);
        hit_data  = mem[look_woff[IDX_W-1:0] & tag_mask];
    end

    // R8: a flush leaves no valid line behind.
    p_flush_invalidates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !valid);
    // R4: a stored line base is aligned to its own burst length.
    p_line_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((tag_base & {{(WOFF_W-IDX_W){1'b0}}, tag_mask}) == '0));
    // R4: a fill never writes past its burst length.
    p_fill_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        filling |-> (cnt <= tag_mask));
endmodule

// File: rtl/xip_fetch_ctrl.sv
`timescale 1ns/1ps
// Request sequencer: answers errors and hits directly, starts a frame
// on a miss and waits for the fill to end before looking again. Assumes
// the host drops hst_req in the cycle after hst_ack.
module xip_fetch_ctrl
    import xip_pkg::*;
#(
    parameter int  MAX_BURST = 32,
    localparam int IDX_W     = $clog2(MAX_BURST),
    localparam int CNT_W     = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hst_req,
    input  logic                 mode_manual,
    input  logic                 mapped,
    input  logic                 hit,
    input  logic [DATA_W-1:0]    hit_data,
    input  logic                 fill_last,
    input  logic [31:0]          base_faddr,
    input  logic [IDX_W-1:0]     line_mask,
    input  logic [CMD_W-1:0]     cfg_cmd,
    input  logic [OPT_W-1:0]     cfg_opt,
    input  logic [PHASE_W-MASK_W-1:0] cfg_phase,
    input  logic [DUMMY_W-1:0]   cfg_dummy,
    input  logic [DDR_W-1:0]     cfg_ddr,
    input  logic [CSD_W-1:0]     cfg_cs_dly,
    output logic                 fill_start,
    output logic                 hst_ack,
    output logic                 hst_err,
    output logic [DATA_W-1:0]    hst_rdata,
    output logic                 fr_start,
    output logic [31:0]          fr_addr,
    output logic [CNT_W-1:0]     fr_words,
    output logic [CMD_W-1:0]     fr_cmd,
    output logic [OPT_W-1:0]     fr_opt,
    output logic [PHASE_W-1:0]   fr_phase,
    output logic [DUMMY_W-1:0]   fr_dummy,
    output logic [DDR_W-1:0]     fr_ddr,
    output logic [CSD_W-1:0]     fr_cs_dly
);
    xip_state_e state;
    logic       accept, reject;

    // Classify the pending request in the idle state.
    always_comb begin
        accept     = hst_req && !hst_ack && (state == ST_IDLE);
        reject     = mode_manual || !mapped;
        fill_start = accept && !reject && !hit;
    end

    // Host response strobe and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hst_ack   <= 1'b0;
            hst_err   <= 1'b0;
            hst_rdata <= '0;
        end else begin
            hst_ack   <= accept && (reject || hit);
            hst_err   <= accept && reject;
            hst_rdata <= (accept && !reject && hit) ? hit_data : '0;
        end
    end

    // Idle/fill sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (fill_start)
            state <= ST_FILL;
        else if (fill_last)
            state <= ST_IDLE;
    end

    // Frame descriptor, captured once per miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_start  <= 1'b0;
            fr_addr   <= '0;
            fr_words  <= '0;
            fr_cmd    <= '0;
            fr_opt    <= '0;
            fr_phase  <= '0;
            fr_dummy  <= '0;
            fr_ddr    <= '0;
            fr_cs_dly <= '0;
        end else begin
            fr_start <= fill_start;
            if (fill_start) begin
                fr_addr   <= base_faddr;
                fr_words  <= CNT_W'(line_mask) + CNT_W'(1);
                fr_cmd    <= cfg_cmd;
                fr_opt    <= cfg_opt;
                fr_phase  <= {cfg_phase, {MASK_W{1'b1}}};
                fr_dummy  <= cfg_dummy;
                fr_ddr    <= cfg_ddr;
                fr_cs_dly <= cfg_cs_dly;
            end
        end
    end

    // R9: a frame start lasts exactly one cycle.
    p_single_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fr_start |=> !fr_start);
    // R6: no response is given while a fill is outstanding.
    p_hold_during_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |=> !hst_ack || $past(fill_last));
    // R1: error responses carry no data and come with the strobe.
    p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hst_err |-> (hst_ack && (hst_rdata == '0)));
    // R9: a response and a frame start never coincide.
    p_no_frame_on_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hst_ack |-> !fr_start);
endmodule

// File: rtl/xip_read_bridge.sv
`timescale 1ns/1ps
// Memory-mapped serial flash read bridge. Decodes a host read window,
// serves hits from a one-line burst cache and issues one read frame to
// an external serial shifter per miss. Assumes the shifter returns
// exactly fr_words words in address order after each fr_start.
module xip_read_bridge
    import xip_pkg::*;
#(
    parameter logic [31:0] WIN_BASE  = 32'h0800_0000,
    parameter int          WIN_BITS  = 26,
    parameter int          MAX_BURST = 32,
    localparam int         WOFF_W    = WIN_BITS - 2,
    localparam int         IDX_W     = $clog2(MAX_BURST),
    localparam int         CNT_W     = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_manual,
    input  logic                 hst_req,
    input  logic [31:0]          hst_addr,
    output logic                 hst_wait,
    output logic                 hst_ack,
    output logic                 hst_err,
    output logic [DATA_W-1:0]    hst_rdata,
    input  logic                 cfg_burst_en,
    input  logic [IDX_W-1:0]     cfg_burst_m1,
    input  logic                 cfg_flush,
    input  logic [EXT_W-1:0]     cfg_ext_addr,
    input  logic [SEL_W-1:0]     cfg_ext_sel,
    input  logic [CMD_W-1:0]     cfg_cmd,
    input  logic [OPT_W-1:0]     cfg_opt,
    input  logic [PHASE_W-MASK_W-1:0] cfg_phase,
    input  logic [DUMMY_W-1:0]   cfg_dummy,
    input  logic [DDR_W-1:0]     cfg_ddr,
    input  logic [CSD_W-1:0]     cfg_cs_dly,
    output logic                 fr_start,
    output logic [31:0]          fr_addr,
    output logic [CNT_W-1:0]     fr_words,
    output logic [CMD_W-1:0]     fr_cmd,
    output logic [OPT_W-1:0]     fr_opt,
    output logic [PHASE_W-1:0]   fr_phase,
    output logic [DUMMY_W-1:0]   fr_dummy,
    output logic [DDR_W-1:0]     fr_ddr,
    output logic [CSD_W-1:0]     fr_cs_dly,
    input  logic                 rx_valid,
    input  logic [DATA_W-1:0]    rx_data
);
    logic              mapped, hit, fill_start, fill_last;
    logic [WOFF_W-1:0] woff, base_woff;
    logic [IDX_W-1:0]  line_mask;
    logic [31:0]       base_faddr;
    logic [DATA_W-1:0] hit_data;

    // Host is held while its request is unanswered.
    assign hst_wait = hst_req && !hst_ack;

    xip_addr_map #(
        .WIN_BASE (WIN_BASE),
        .WIN_BITS (WIN_BITS),
        .MAX_BURST(MAX_BURST)
    ) u_map (
        .addr      (hst_addr),
        .burst_en  (cfg_burst_en),
        .burst_m1  (cfg_burst_m1),
        .ext_addr  (cfg_ext_addr),
        .ext_sel   (cfg_ext_sel),
        .mapped    (mapped),
        .woff      (woff),
        .base_woff (base_woff),
        .line_mask (line_mask),
        .base_faddr(base_faddr)
    );

    xip_line_cache #(
        .MAX_BURST(MAX_BURST),
        .WOFF_W   (WOFF_W)
    ) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cfg_flush),
        .fill_start(fill_start),
        .fill_base (base_woff),
        .fill_mask (line_mask),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .look_woff (woff),
        .hit       (hit),
        .hit_data  (hit_data),
        .fill_last (fill_last)
    );

    xip_fetch_ctrl #(
        .MAX_BURST(MAX_BURST)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hst_req    (hst_req),
        .mode_manual(mode_manual),
        .mapped     (mapped),
        .hit        (hit),
        .hit_data   (hit_data),
        .fill_last  (fill_last),
        .base_faddr (base_faddr),
        .line_mask  (line_mask),
        .cfg_cmd    (cfg_cmd),
        .cfg_opt    (cfg_opt),
        .cfg_phase  (cfg_phase),
        .cfg_dummy  (cfg_dummy),
        .cfg_ddr    (cfg_ddr),
        .cfg_cs_dly (cfg_cs_dly),
        .fill_start (fill_start),
        .hst_ack    (hst_ack),
        .hst_err    (hst_err),
        .hst_rdata  (hst_rdata),
        .fr_start   (fr_start),
        .fr_addr    (fr_addr),
        .fr_words   (fr_words),
        .fr_cmd     (fr_cmd),
        .fr_opt     (fr_opt),
        .fr_phase   (fr_phase),
        .fr_dummy   (fr_dummy),
        .fr_ddr     (fr_ddr),
        .fr_cs_dly  (fr_cs_dly)
    );

    // R2: manual sequencing mode never launches a frame.
    p_manual_no_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_manual && $past(mode_manual)) |-> !fr_start);
endmodule

// File: tb/xip_read_bridge_bench.sv
`timescale 1ns/1ps
// Self-checking bench: models the serial shifter inline and sweeps
// burst lengths, window edges, address modes and flushes.
module xip_read_bridge_bench;
    localparam logic [31:0] WB = 32'h0800_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_manual = 1'b0;
    logic        hst_req = 1'b0;
    logic [31:0] hst_addr = '0;
    logic        hst_wait, hst_ack, hst_err;
    logic [31:0] hst_rdata;
    logic        cfg_burst_en = 1'b1;
    logic [4:0]  cfg_burst_m1 = 5'd7;
    logic        cfg_flush = 1'b0;
    logic [3:0]  cfg_ext_addr = 4'h5;
    logic [2:0]  cfg_ext_sel = 3'd1;
    logic [15:0] cfg_cmd = 16'h0C3E;
    logic [31:0] cfg_opt = 32'hCAFE_0011;
    logic [27:0] cfg_phase = 28'hA5C_3F02;
    logic [4:0]  cfg_dummy = 5'd9;
    logic [15:0] cfg_ddr = 16'h1101;
    logic [8:0]  cfg_cs_dly = 9'o537;
    logic        fr_start;
    logic [31:0] fr_addr;
    logic [5:0]  fr_words;
    logic [15:0] fr_cmd;
    logic [31:0] fr_opt;
    logic [31:0] fr_phase;
    logic [4:0]  fr_dummy;
    logic [15:0] fr_ddr;
    logic [8:0]  fr_cs_dly;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    xip_read_bridge u_xip_read_bridge (
        .clk(clk), .rst_n(rst_n), .mode_manual(mode_manual),
        .hst_req(hst_req), .hst_addr(hst_addr), .hst_wait(hst_wait),
        .hst_ack(hst_ack), .hst_err(hst_err), .hst_rdata(hst_rdata),
        .cfg_burst_en(cfg_burst_en), .cfg_burst_m1(cfg_burst_m1),
        .cfg_flush(cfg_flush), .cfg_ext_addr(cfg_ext_addr),
        .cfg_ext_sel(cfg_ext_sel), .cfg_cmd(cfg_cmd), .cfg_opt(cfg_opt),
        .cfg_phase(cfg_phase), .cfg_dummy(cfg_dummy), .cfg_ddr(cfg_ddr),
        .cfg_cs_dly(cfg_cs_dly), .fr_start(fr_start), .fr_addr(fr_addr),
        .fr_words(fr_words), .fr_cmd(fr_cmd), .fr_opt(fr_opt),
        .fr_phase(fr_phase), .fr_dummy(fr_dummy), .fr_ddr(fr_ddr),
        .fr_cs_dly(fr_cs_dly), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    // Flash content model: a distinct word per byte address.
    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
    endfunction

    // R3 address forming from the window offset.
    function automatic logic [31:0] faddr(input logic [31:0] off);
        if (cfg_ext_sel == 3'd0) return {8'h00, off[23:0]};
        else return {3'b000, cfg_ext_addr, off[24:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic flush_line();
        @(negedge clk); cfg_flush = 1'b1;
        @(negedge clk); cfg_flush = 1'b0;
    endtask

    // One host read with the shifter modelled in the same process.
    task automatic rd(input logic [31:0] a, input bit exp_err, input int exp_frames,
                      input string req);
        int frames = 0;
        int k = 0;
        int fw = 0;
        int lat = 0;
        logic [31:0] fa = '0;
        bit got = 0;
        bit wait_ok = 1;
        logic [31:0] data = '0;
        logic err = 1'b0;
        logic [31:0] m = cfg_burst_en ? {27'd0, cfg_burst_m1} : 32'd0;
        logic [31:0] bword = {8'd0, a[25:2]} & ~m;
        @(negedge clk);
        hst_req = 1'b1; hst_addr = a;
        for (int cyc = 0; cyc < 400 && !got; cyc++) begin
            @(negedge clk);
            rx_valid = 1'b0;
            if (fr_start) begin
                frames++; fa = fr_addr; fw = int'(fr_words); k = 0;
                chk(fr_addr == faddr(bword << 2), "R3/R4 frame address", fr_addr, faddr(bword << 2));
                chk(32'(fr_words) == m + 1, "R4 frame length", 32'(fr_words), m + 1);
                chk(fr_phase == {cfg_phase, 4'hF}, "R7 phase with forced mask", fr_phase, {cfg_phase, 4'hF});
                chk(fr_cmd == cfg_cmd && fr_opt == cfg_opt && fr_dummy == cfg_dummy &&
                    fr_ddr == cfg_ddr && fr_cs_dly == cfg_cs_dly, "R7 frame fields",
                    {16'd0, fr_cmd}, {16'd0, cfg_cmd});
            end
            if (k < fw) begin
                rx_valid = 1'b1; rx_data = pat(fa + 32'(4 * k)); k++;
            end
            if (hst_ack) begin
                got = 1; data = hst_rdata; err = hst_err; lat = cyc;
                if (hst_wait) wait_ok = 0;
            end else if (!hst_wait) wait_ok = 0;
        end
        hst_req = 1'b0; rx_valid = 1'b0;
        chk(got, {req, " response arrives"}, 32'(got), 32'd1);
        chk(err == exp_err, {req, " error flag"}, 32'(err), 32'(exp_err));
        chk(frames == exp_frames, {req, " R9 frame count"}, 32'(frames), 32'(exp_frames));
        chk(wait_ok, {req, " R6 wait held until ack"}, 32'(wait_ok), 32'd1);
        if (exp_err)
            chk(data == '0, {req, " R1 error data"}, data, 32'd0);
        else
            chk(data == pat(faddr({6'd0, a[25:2], 2'b00})), {req, " read data"}, data,
                pat(faddr({6'd0, a[25:2], 2'b00})));
        if (exp_frames == 0)
            chk(lat == 0, {req, " R5/R1 one-cycle response"}, 32'(lat), 32'd0);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!hst_ack && !fr_start && !hst_wait, "R6 reset state", {29'd0, hst_ack, fr_start, hst_wait}, 32'd0);

        // R2: manual mode rejects window reads.
        mode_manual = 1'b1;
        rd(WB + 32'h100, 1, 0, "R2 manual");
        mode_manual = 1'b0;
        rd(WB + 32'h100, 0, 1, "R2 mapped");

        // R1: window edges and misalignment.
        rd(32'h0400_0000, 1, 0, "R1 below window");
        rd(WB - 32'd4, 1, 0, "R1 just below");
        rd(WB + 32'h0400_0000, 1, 0, "R1 just above");
        rd(WB + 32'h102, 1, 0, "R1 misaligned");
        rd(WB + 32'h03FF_FFFC, 0, 1, "R1 last word");

        // R4/R5: sweep every burst length, miss mid-line then read all.
        for (int e = 0; e < 6; e++) begin
            int len = 1 << e;
            int b = 32'h1000 + e * 64;
            cfg_burst_en = 1'b1;
            cfg_burst_m1 = 5'(len - 1);
            flush_line();
            rd(WB + 32'((b + (len * 3) / 4) * 4), 0, 1, "R4 burst miss");
            for (int w = 0; w < len; w++)
                rd(WB + 32'((b + w) * 4), 0, 0, "R5 burst hit");
            rd(WB + 32'((b + len) * 4), 0, 1, "R6 next line miss");
        end

        // R4: disabled burst ignores the length field.
        cfg_burst_en = 1'b0; cfg_burst_m1 = 5'd31;
        flush_line();
        rd(WB + 32'h2008, 0, 1, "R4 single word");
        rd(WB + 32'h2008, 0, 0, "R5 single word hit");
        rd(WB + 32'h200C, 0, 1, "R4 neighbour not cached");

        // R3: 24-bit vs extended addressing on an offset with bit 24 set.
        cfg_burst_en = 1'b1; cfg_burst_m1 = 5'd3;
        cfg_ext_sel = 3'd0; flush_line();
        rd(WB + 32'h0123_4568, 0, 1, "R3 24-bit");
        cfg_ext_sel = 3'd6; cfg_ext_addr = 4'hA; flush_line();
        rd(WB + 32'h0323_4568, 0, 1, "R3 extended");

        // R7: mask nibble forced regardless of other phase bits.
        cfg_phase = 28'h0000_000; cfg_cmd = 16'h6B00; flush_line();
        rd(WB + 32'h40, 0, 1, "R7 fields");

        // R8: flush forces a refetch of a cached word.
        rd(WB + 32'h44, 0, 0, "R8 cached before flush");
        flush_line();
        rd(WB + 32'h44, 0, 1, "R8 refetch after flush");
        rd(WB + 32'h48, 0, 0, "R8 line refilled");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule